// File: doc/BRIEF.md
# Query Response Lane Replicator

This block builds the read word a parallel flash bank returns while it sits in table-query mode or identifier mode. The bank is made of several identical devices side by side, each of which may be a wide part strapped to a narrower interface. From the bus address and four width settings (access, bank, device and the device's widest native width) it derives the table offset every device would see. It fetches one byte per bank slice from an external query table, or picks an identifier value, and spreads that value over every device lane and every bank slice of the access.

The data path is combinational from address and configuration to a single capture register loaded by a read strobe. A two-state controller marks the cycle after each strobe. The states are `ST_IDLE` (no fresh word) and `ST_RESP` (the word captured on the last edge is on `rd_data`). The transitions are: `ST_IDLE -> ST_RESP` on a strobe, `ST_RESP -> ST_RESP` on a back-to-back strobe, and `ST_RESP -> ST_IDLE` when no strobe is present. The table contents live outside the block. It drives one table index per slice and takes the matching byte back in the same cycle.

All width inputs are log2 codes: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. Legal settings have device width no wider than either the bank width or the native width.

Top module: `qresp_fanout`

## Requirements
- R1: After reset `rd_vld` is 0 and `rd_data` is 0.
- R2: A strobe on a clock edge makes `rd_vld` 1 and presents the response on `rd_data` from that edge on. Without a strobe, `rd_vld` is 0 on the next cycle and `rd_data` keeps its value.
- R3: With `dev_given`=1, the offset for a slice is its address shifted right by `bank_lg + maxdev_lg - dev_lg` (codes as above: 0=1 byte, 1=2 bytes, 2=4 bytes).
- R4: A table offset at or above `TBL_LEN` yields a zero byte in place of the table byte.
- R5: Within a bank slice, byte j equals byte (j mod device bytes) of the per-device response. In table mode with equal device and native widths, the per-device response is the table byte zero-extended, so a 2-byte device shows zero in its upper byte.
- R6: In table mode with `dev_lg`=0 and `maxdev_lg`>0, the table byte fills every byte of the native width. With `dev_lg`>0 and `dev_lg`≠`maxdev_lg`, the response is zero.
- R7: When the access is wider than the bank, slice k occupies bytes k·bank..k·bank+bank-1. It is computed from address `addr + k·bank`.
- R8: In identifier mode with `dev_given`=1, only the low 8 bits of the offset are decoded: 0 gives `id_w0`, 1 gives `id_w1`, any other value gives 0.
- R9: With `dev_given`=0, the offset is `addr[7:0] >> bank_lg`. The table byte alone is returned in byte 0, without replication or slicing.
- R10: In identifier mode with `dev_given`=0, offset 0 returns {`id_w0`,`id_w1`}, offset 1 returns {`id_w2`,`id_w3`}, and any other offset returns 0.
- R11: Bytes at or above the access width (1 << `acc_lg`) of `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read strobe; captures the response |
| addr | input | ADDR_W | Bus byte address |
| acc_lg | input | LG_W | log2 of access width in bytes |
| bank_lg | input | LG_W | log2 of bank width in bytes |
| dev_lg | input | LG_W | log2 of device width in bytes |
| maxdev_lg | input | LG_W | log2 of device native width in bytes |
| dev_given | input | 1 | 1: device width is configured; 0: legacy decoding |
| sel_table | input | 1 | 1: table-query mode; 0: identifier mode |
| id_w0 | input | ID_W | Manufacturer code |
| id_w1 | input | ID_W | Device code |
| id_w2 | input | ID_W | Extra identifier (legacy word 1, high part) |
| id_w3 | input | ID_W | Extra identifier (legacy word 1, low part) |
| rom_idx | output | DATA_BYTES*IDX_W | Table index per slice, slice 0 lowest |
| rom_data | input | DATA_BYTES*8 | Table byte per slice, slice 0 lowest |
| rd_vld | output | 1 | High in the cycle after a strobe |
| rd_data | output | DATA_BYTES*8 | Captured response |

## Verification
The bench builds the block with a 4-byte data path, a 16-bit address, an 82-entry table and 8-bit identifiers. These values put every legal mix of 1-, 2- and 4-byte bank, device and native widths in reach, along with shifts from 0 to 4 and up to four bank slices in one access. With 16-bit addresses, offsets land well past the table end, and the low-byte identifier decode can be probed with high offset bits set. Random legal configurations are checked against a bench model, alongside directed cases at the table boundary, the illegal narrow setting and the legacy paths.

// File: rtl/qresp_pkg.sv
package qresp_pkg;

    // Capture controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } cap_state_e;

endpackage

// File: rtl/qresp_slice_off.sv
// Per-slice offset: rescales the address of one bank slice into the
// offset a single device sees.
module qresp_slice_off #(
    parameter int ADDR_W = 24,
    parameter int LG_W   = 2,
    parameter int SLICE  = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LG_W-1:0]   bank_lg,
    input  logic [LG_W-1:0]   dev_lg,
    input  logic [LG_W-1:0]   maxdev_lg,
    input  logic              dev_given,
    output logic [ADDR_W-1:0] off
);
    localparam int SH_W = LG_W + 1;

    logic [ADDR_W-1:0] slice_addr;
    logic [SH_W-1:0]   shamt;

    always_comb begin
        slice_addr = addr + (ADDR_W'(SLICE) << bank_lg);
        shamt      = SH_W'(bank_lg) + SH_W'(maxdev_lg) - SH_W'(dev_lg);
        if (dev_given) begin
            off = slice_addr >> shamt;
        end else begin
            off = ADDR_W'(addr[7:0] >> bank_lg);
        end
    end
endmodule

// File: rtl/qresp_dev_resp.sv
// Forms one bank slice: per-device response, then fan-out over device lanes.
module qresp_dev_resp #(
    parameter int ADDR_W     = 24,
    parameter int LG_W       = 2,
    parameter int DATA_BYTES = 4,
    parameter int TBL_LEN    = 82,
    parameter int ID_W       = 8
) (
    input  logic [ADDR_W-1:0]       off,
    input  logic                    sel_table,
    input  logic                    dev_given,
    input  logic [7:0]              rom_byte,
    input  logic [ID_W-1:0]         id_w0,
    input  logic [ID_W-1:0]         id_w1,
    input  logic [ID_W-1:0]         id_w2,
    input  logic [ID_W-1:0]         id_w3,
    input  logic [LG_W-1:0]         bank_lg,
    input  logic [LG_W-1:0]         dev_lg,
    input  logic [LG_W-1:0]         maxdev_lg,
    output logic [8*DATA_BYTES-1:0] slice_word
);
    localparam int DATA_W = 8 * DATA_BYTES;

    logic [7:0]        tbl_byte;
    logic [DATA_W-1:0] dresp;
    logic [DATA_W-1:0] fanned;
    logic [DATA_W-1:0] legacy;

    always_comb begin
        tbl_byte = (off < ADDR_W'(TBL_LEN)) ? rom_byte : 8'h00;

        // Response of one device
        dresp = '0;
        if (sel_table) begin
            if (dev_lg == maxdev_lg) begin
                dresp[7:0] = tbl_byte;
            end else if (dev_lg == '0) begin
                for (int i = 0; i < DATA_BYTES; i++) begin
                    if (i < (1 << maxdev_lg)) dresp[8*i +: 8] = tbl_byte;
                end
            end
        end else begin
            if (off[7:0] == 8'd0)      dresp = DATA_W'(id_w0);
            else if (off[7:0] == 8'd1) dresp = DATA_W'(id_w1);
        end

        // Copy the device lanes over the bank width
        fanned = '0;
        for (int j = 0; j < DATA_BYTES; j++) begin
            if (j < (1 << bank_lg)) begin
                fanned[8*j +: 8] = dresp[8*(j & ((1 << dev_lg) - 1)) +: 8];
            end
        end

        // Legacy decoding when no device width is configured
        legacy = '0;
        if (sel_table) begin
            legacy = DATA_W'(tbl_byte);
        end else if (off == '0) begin
            legacy = DATA_W'({id_w0, id_w1});
        end else if (off == ADDR_W'(1)) begin
            legacy = DATA_W'({id_w2, id_w3});
        end

        slice_word = dev_given ? fanned : legacy;
    end
endmodule

// File: rtl/qresp_capture_fsm.sv
// Capture register and strobe-tracking controller.
module qresp_capture_fsm
    import qresp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] next_data,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data
);
    cap_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = rd_stb ? ST_RESP : ST_IDLE;
            ST_RESP: state_nxt = rd_stb ? ST_RESP : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= next_data;
    end

    assign rd_vld = (state == ST_RESP);
endmodule

// File: rtl/qresp_fanout.sv
// Top: per-slice offsets and responses, slice assembly, access masking.
module qresp_fanout #(
    parameter int ADDR_W     = 24,
    parameter int DATA_BYTES = 4,
    parameter int TBL_LEN    = 82,
    parameter int ID_W       = 8,
    localparam int LG_W      = $clog2($clog2(DATA_BYTES) + 1),
    localparam int IDX_W     = $clog2(TBL_LEN),
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_stb,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LG_W-1:0]             acc_lg,
    input  logic [LG_W-1:0]             bank_lg,
    input  logic [LG_W-1:0]             dev_lg,
    input  logic [LG_W-1:0]             maxdev_lg,
    input  logic                        dev_given,
    input  logic                        sel_table,
    input  logic [ID_W-1:0]             id_w0,
    input  logic [ID_W-1:0]             id_w1,
    input  logic [ID_W-1:0]             id_w2,
    input  logic [ID_W-1:0]             id_w3,
    output logic [DATA_BYTES*IDX_W-1:0] rom_idx,
    input  logic [DATA_BYTES*8-1:0]     rom_data,
    output logic                        rd_vld,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int NSLICE = DATA_BYTES;
    localparam int SL_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1;

    logic [ADDR_W-1:0] slice_off  [NSLICE];
    logic [DATA_W-1:0] slice_word [NSLICE];
    logic [DATA_W-1:0] lanes;
    logic [DATA_W-1:0] picked;
    logic [LG_W-1:0]   nsl_lg;
    int                k_sl;
    int                j_by;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        qresp_slice_off #(
            .ADDR_W (ADDR_W),
            .LG_W   (LG_W),
            .SLICE  (s)
        ) i_off (
            .addr      (addr),
            .bank_lg   (bank_lg),
            .dev_lg    (dev_lg),
            .maxdev_lg (maxdev_lg),
            .dev_given (dev_given),
            .off       (slice_off[s])
        );

        assign rom_idx[s*IDX_W +: IDX_W] = slice_off[s][IDX_W-1:0];

        qresp_dev_resp #(
            .ADDR_W     (ADDR_W),
            .LG_W       (LG_W),
            .DATA_BYTES (DATA_BYTES),
            .TBL_LEN    (TBL_LEN),
            .ID_W       (ID_W)
        ) i_resp (
            .off        (slice_off[s]),
            .sel_table  (sel_table),
            .dev_given  (dev_given),
            .rom_byte   (rom_data[8*s +: 8]),
            .id_w0      (id_w0),
            .id_w1      (id_w1),
            .id_w2      (id_w2),
            .id_w3      (id_w3),
            .bank_lg    (bank_lg),
            .dev_lg     (dev_lg),
            .maxdev_lg  (maxdev_lg),
            .slice_word (slice_word[s])
        );
    end

    // Place each bank slice into its byte range, then clip to the access
    always_comb begin
        nsl_lg = (acc_lg > bank_lg) ? (acc_lg - bank_lg) : '0;
        lanes  = '0;
        k_sl   = 0;
        j_by   = 0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            k_sl = b >> bank_lg;
            j_by = b - (k_sl << bank_lg);
            if (k_sl < (1 << nsl_lg)) begin
                lanes[8*b +: 8] = slice_word[SL_W'(k_sl)][8*j_by +: 8];
            end
        end
        picked = dev_given ? lanes : slice_word[0];
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (b >= (1 << acc_lg)) picked[8*b +: 8] = 8'h00;
        end
    end

    qresp_capture_fsm #(
        .DATA_W (DATA_W)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .next_data (picked),
        .rd_vld    (rd_vld),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/qresp_fanout_chk.sv
module qresp_fanout_chk #(
    parameter int DATA_BYTES = 4,
    parameter int LG_W       = 2,
    parameter int DATA_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic [LG_W-1:0]   acc_lg,
    input logic [LG_W-1:0]   bank_lg,
    input logic [LG_W-1:0]   dev_lg,
    input logic              dev_given,
    input logic              sel_table,
    input logic              rd_vld,
    input logic [DATA_W-1:0] rd_data
);
    function automatic logic [DATA_W-1:0] acc_mask(input logic [LG_W-1:0] lg);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (b < (1 << lg)) m[8*b +: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic all_same(input logic [DATA_W-1:0] d);
        logic ok;
        ok = 1'b1;
        for (int b = 1; b < DATA_BYTES; b++) begin
            if (d[8*b +: 8] != d[7:0]) ok = 1'b0;
        end
        return ok;
    endfunction

    p_vld_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_vld);

    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_vld);

    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    p_acc_clip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> ((rd_data & ~acc_mask($past(acc_lg))) == '0));

    p_byte_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && dev_given && dev_lg == '0 && bank_lg == LG_W'(2) && acc_lg == LG_W'(2))
        |=> all_same(rd_data));

    p_legacy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !dev_given && sel_table) |=> (rd_data[DATA_W-1:8] == '0));
endmodule

bind qresp_fanout qresp_fanout_chk #(
    .DATA_BYTES (DATA_BYTES),
    .LG_W       (LG_W),
    .DATA_W     (DATA_W)
) i_qresp_chk (.*);

// File: tb/test_qresp_fanout.sv
`timescale 1ns/1ps
module test_qresp_fanout;
    localparam int AW  = 16;
    localparam int DB  = 4;
    localparam int TL  = 82;
    localparam int IW  = 8;
    localparam int LW  = 2;
    localparam int IXW = 7;
    localparam int DW  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_stb = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [LW-1:0]   acc_lg = '0, bank_lg = '0, dev_lg = '0, maxdev_lg = '0;
    logic            dev_given = 1'b0, sel_table = 1'b0;
    logic [IW-1:0]   id_w0 = 8'h89, id_w1 = 8'h18, id_w2 = 8'h5A, id_w3 = 8'hC3;
    logic [DB*IXW-1:0] rom_idx;
    logic [DB*8-1:0] rom_data;
    logic            rd_vld;
    logic [DW-1:0]   rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rom_fn(input int i);
        return 8'((i * 29 + 91) & 255);
    endfunction

    always_comb begin
        for (int s = 0; s < DB; s++) rom_data[8*s +: 8] = rom_fn(int'(rom_idx[s*IXW +: IXW]));
    end

    qresp_fanout #(.ADDR_W(AW), .DATA_BYTES(DB), .TBL_LEN(TL), .ID_W(IW)) i_qresp_fanout (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr(addr),
        .acc_lg(acc_lg), .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg),
        .dev_given(dev_given), .sel_table(sel_table),
        .id_w0(id_w0), .id_w1(id_w1), .id_w2(id_w2), .id_w3(id_w3),
        .rom_idx(rom_idx), .rom_data(rom_data), .rd_vld(rd_vld), .rd_data(rd_data));

    // Expected response from the requirements
    function automatic logic [DW-1:0] model(input logic [AW-1:0] a, input bit tbl, input bit given,
                                            input int bl, input int dl, input int ml, input int al);
        logic [DW-1:0] r, dresp;
        logic [AW-1:0] sa, o;
        int nb, db, mb, ab, sh, ns;
        logic [7:0] by;
        r = '0;
        nb = 1 << bl; db = 1 << dl; mb = 1 << ml; ab = 1 << al;
        if (!given) begin
            o = AW'(a[7:0] >> bl);
            if (tbl) r = (int'(o) < TL) ? DW'(rom_fn(int'(o))) : '0;
            else if (o == 0) r = DW'({id_w0, id_w1});
            else if (o == 1) r = DW'({id_w2, id_w3});
        end else begin
            sh = bl + ml - dl;
            ns = (ab > nb) ? ab / nb : 1;
            for (int s = 0; s < ns; s++) begin
                sa = a + AW'(s * nb);
                o = sa >> sh;
                dresp = '0;
                if (tbl) begin
                    by = (int'(o) < TL) ? rom_fn(int'(o)) : 8'h00;
                    if (dl == ml) dresp[7:0] = by;
                    else if (dl == 0) for (int i = 0; i < mb; i++) dresp[8*i +: 8] = by;
                end else begin
                    if (o[7:0] == 0) dresp = DW'(id_w0);
                    else if (o[7:0] == 1) dresp = DW'(id_w1);
                end
                for (int j = 0; j < nb; j++) r[8*(s*nb + j) +: 8] = dresp[8*(j % db) +: 8];
            end
        end
        for (int b = 0; b < DB; b++) if (b >= ab) r[8*b +: 8] = 8'h00;
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input bit tbl, input bit given,
                      input int bl, input int dl, input int ml, input int al);
        logic [DW-1:0] exp;
        @(negedge clk);
        addr = a; sel_table = tbl; dev_given = given;
        bank_lg = LW'(bl); dev_lg = LW'(dl); maxdev_lg = LW'(ml); acc_lg = LW'(al);
        rd_stb = 1'b1;
        exp = model(a, tbl, given, bl, dl, ml, al);
        @(negedge clk);
        rd_stb = 1'b0;
        check({tag, " R2 vld"}, DW'(rd_vld), 1);
        check(tag, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 reset vld", DW'(rd_vld), 0);
        check("R1 reset data", rd_data, 0);
        rst_n = 1'b1;

        // R3: shift of 3 (bank 4, dev 1, native 2)
        rd("R3 off 0x10", 16'h0080, 1, 1, 2, 0, 1, 2);
        check("R3 literal", rd_data, {4{rom_fn(16)}});
        rd("R3 off 0x11", 16'h0088, 1, 1, 2, 0, 1, 2);
        // R4: table boundary
        rd("R4 last entry", 16'd81, 1, 1, 0, 0, 0, 0);
        check("R4 literal", rd_data, DW'(rom_fn(81)));
        rd("R4 past end", 16'd82, 1, 1, 0, 0, 0, 0);
        check("R4 zero", rd_data, 0);
        // R5: 2-byte devices in a 4-byte bank
        rd("R5 dev2", 16'h0044, 1, 1, 2, 1, 1, 2);
        check("R5 literal", rd_data, {8'h00, rom_fn(17), 8'h00, rom_fn(17)});
        // R6: narrow mode and the illegal narrow setting
        rd("R6 narrow", 16'h0006, 1, 1, 0, 0, 1, 0);
        check("R6 narrow literal", rd_data, DW'(rom_fn(3)));
        rd("R6 illegal", 16'h0040, 1, 1, 2, 1, 2, 2);
        check("R6 zero", rd_data, 0);
        // R7: wide access over a 1-byte bank
        rd("R7 slices", 16'h0020, 1, 1, 0, 0, 0, 2);
        check("R7 literal", rd_data, {rom_fn(35), rom_fn(34), rom_fn(33), rom_fn(32)});
        rd("R7 two slices", 16'h0010, 1, 1, 1, 1, 1, 2);
        // R8: identifier decode on low offset byte
        rd("R8 mfr", 16'h0100, 0, 1, 0, 0, 0, 0);
        check("R8 mfr literal", rd_data, DW'(id_w0));
        rd("R8 dev", 16'h0201, 0, 1, 0, 0, 0, 0);
        check("R8 dev literal", rd_data, DW'(id_w1));
        rd("R8 other", 16'h0002, 0, 1, 0, 0, 0, 0);
        check("R8 zero", rd_data, 0);
        // R9: legacy table offset
        rd("R9 legacy", 16'h0124, 1, 0, 1, 0, 0, 2);
        check("R9 literal", rd_data, DW'(rom_fn(18)));
        // R10: legacy identifier words
        rd("R10 word0", 16'h0000, 0, 0, 2, 0, 0, 1);
        check("R10 word0 literal", rd_data, {16'h0, id_w0, id_w1});
        rd("R10 word1", 16'h0004, 0, 0, 2, 0, 0, 1);
        check("R10 word1 literal", rd_data, {16'h0, id_w2, id_w3});
        // R11: 1-byte access on a 4-byte bank
        rd("R11 clip", 16'h0008, 1, 1, 2, 0, 0, 0);
        check("R11 literal", rd_data, DW'(rom_fn(2)));

        // R2: hold without strobe
        held = rd_data;
        @(negedge clk);
        check("R2 idle vld", DW'(rd_vld), 0);
        check("R2 hold", rd_data, held);

        // Random legal configurations
        for (int n = 0; n < 400; n++) begin
            int dl, ml, bl, al;
            logic [AW-1:0] a;
            dl = int'($urandom % 3);
            ml = dl + int'($urandom % (3 - dl));
            bl = dl + int'($urandom % (3 - dl));
            al = int'($urandom % 3);
            a = AW'($urandom);
            if ($urandom % 2 == 0) a = a & 16'h01FF;
            rd("R7 random", a, bit'($urandom % 2), ($urandom % 5) != 0, bl, dl, ml, al);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule